// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the wakeup logic and the execution units of an out-of-order core. Instructions whose operands are ready are pushed into it, one per cycle, each carrying an operation class, a sequence number, a thread identifier and a flag saying whether it accesses memory. Every class keeps its own queue sorted so that its oldest instruction is always at the front.

Each cycle the selector walks the classes from the one with the oldest front entry to the youngest, granting issue while the issue width lasts and the downstream stage can accept. A class whose functional unit is busy is passed over and a per-class, per-thread busy counter records the miss. Class 0 denotes operations that need no functional unit. The selector also tells the unit pool when each unit may be reused and tells the entry allocator when a queue slot is free again.

A squash request marks the younger instructions of one thread as dead. Dead instructions are thrown away when they reach the front of their class, without costing issue bandwidth.

Top module: `oldest_issue_select`

## Requirements
- R1: Within a class the front entry is always the queued instruction with the smallest sequence number (unsigned); a push older than the current front becomes the new front.
- R2: With exec_ready high, a class is granted in a cycle exactly when its live front entry needs no unit or has one free (fu_avail bit c-1 for class c), and fewer than ISSUE_W such classes have an older live front; at most one grant per class per cycle, and issue_seq/issue_tid/issue_mem of a granted class show its front entry in the same cycle.
- R3: No more than ISSUE_W bits of issue_grant are set in any cycle.
- R4: While exec_ready is low there are no grants, no entries are discarded and the busy counters hold.
- R5: While exec_ready is high, squashed entries ahead of the first live entry of a class are removed that cycle, use no issue width, and the live entry behind them is eligible in the same cycle.
- R6: A class whose live front is reached by the walk (fewer than ISSUE_W older eligible classes) but whose unit is not free gets no grant, and the counter at busy_count[((c*NUM_THREADS)+tid)*BUSY_W +: BUSY_W] for that class and the front entry's thread rises by one on the next cycle; younger classes may still be granted.
- R7: Class 0 is granted without any unit and never asserts fu_release.
- R8: For class c>0 with latency 1 or a pipelined unit, fu_release[c] is high the cycle after the grant; for an unpipelined unit of latency L>1 it is high exactly L cycles after the grant (defaults: class 1 latency 1, class 2 latency 3 pipelined, class 3 latency 4 unpipelined).
- R9: entry_release[c] is high the cycle after a grant of a non-memory instruction of class c and stays low after a grant of a memory instruction.
- R10: A squash of thread T at sequence S marks every queued or same-cycle pushed instruction of thread T with a sequence number greater than S (unsigned); other threads and older entries are untouched.
- R11: After reset all queues are empty, no grant or release is asserted and all busy counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | A ready instruction is presented |
| push_class | input | $clog2(NUM_CLASSES) | Operation class of the pushed instruction |
| push_seq | input | SEQ_W | Sequence number of the pushed instruction |
| push_tid | input | TID_W | Thread of the pushed instruction |
| push_mem | input | 1 | Pushed instruction accesses memory |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Thread being squashed |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| fu_avail | input | NUM_CLASSES-1 | Bit c-1 set when class c has a free unit |
| exec_ready | input | 1 | Downstream stage can accept issue |
| issue_grant | output | NUM_CLASSES | Per-class issue grant |
| issue_seq | output | NUM_CLASSES*SEQ_W | Sequence number of each class front, field c at c*SEQ_W |
| issue_tid | output | NUM_CLASSES*TID_W | Thread of each class front, field c at c*TID_W |
| issue_mem | output | NUM_CLASSES | Memory flag of each class front |
| fu_release | output | NUM_CLASSES | Unit of class c may be reused |
| entry_release | output | NUM_CLASSES | A queue slot of class c was freed by a non-memory issue |
| busy_count | output | NUM_CLASSES*NUM_THREADS*BUSY_W | Wrapping unit-busy counters per class and thread |

## Verification
Grants and the front-entry fields are combinational, so they are due in the same cycle as the queue state and exec_ready/fu_avail that produce them; entry_release, fast fu_release and busy counter updates appear one clock later, and a held unit's fu_release appears L clocks after its grant. The bench drives inputs just after a rising edge, compares all outputs 2 ns later against a queue-based reference model that reflects every earlier edge, and only then lets the model advance at the next rising edge. Directed sequences cover out-of-order pushes, width saturation, busy units, class 0, and squashes that strike fronts and other threads, followed by a long random run with stalls, random unit availability and squashes.

// File: rtl/ois_pkg.sv
// Shared constants and helpers for the oldest-first issue selector.
// Assumes per-class latencies are packed LAT_W bits per class.
package ois_pkg;
    localparam int LAT_W = 4;

    // True when a unit can be handed back on the cycle after issue.
    function automatic bit early_free(int lat, bit pipelined);
        return (lat <= 1) || pipelined;
    endfunction
endpackage

// File: rtl/ois_class_queue.sv
// One per-class ready queue, kept sorted oldest-first by sequence number.
// Assumes sequence numbers are unique and the allocator never pushes into
// a full queue. Leading squashed entries are dropped when 'drop' is high;
// 'pop' removes the live front (the caller pops only when it is valid).
module ois_class_queue #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int TID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_v,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [TID_W-1:0] push_tid,
    input  logic             push_mem,
    input  logic             sq_v,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             drop,
    input  logic             pop,
    output logic             head_v,
    output logic [SEQ_W-1:0] head_seq,
    output logic [TID_W-1:0] head_tid,
    output logic             head_mem
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [SEQ_W-1:0] seq_q [DEPTH];
    logic [TID_W-1:0] tid_q [DEPTH];
    logic [DEPTH-1:0] mem_q, dead_q;
    logic [CNT_W-1:0] cnt_q;

    logic [SEQ_W-1:0] t_seq [DEPTH];
    logic [TID_W-1:0] t_tid [DEPTH];
    logic [DEPTH-1:0] t_mem, t_dead;
    logic [SEQ_W-1:0] n_seq [DEPTH];
    logic [TID_W-1:0] n_tid [DEPTH];
    logic [DEPTH-1:0] n_mem, n_dead;
    logic [CNT_W-1:0] n_cnt;
    int               lead;
    logic             push_dead;

    // Find the first entry that has not been squashed.
    always_comb begin
        lead     = int'(cnt_q);
        head_v   = 1'b0;
        head_seq = seq_q[0];
        head_tid = tid_q[0];
        head_mem = mem_q[0];
        for (int i = 0; i < DEPTH; i++) begin
            if (!head_v && i < int'(cnt_q) && !dead_q[i]) begin
                lead     = i;
                head_v   = 1'b1;
                head_seq = seq_q[i];
                head_tid = tid_q[i];
                head_mem = mem_q[i];
            end
        end
    end

    assign push_dead = sq_v && (push_tid == sq_tid) && (push_seq > sq_seq);

    // Remove the front, apply the squash, then insert the push in order.
    always_comb begin
        int k;
        int live;
        int pos;
        k    = (drop ? lead : 0) + (pop ? 1 : 0);
        live = int'(cnt_q) - k;
        for (int i = 0; i < DEPTH; i++) begin
            if (i + k < DEPTH) begin
                t_seq[i]  = seq_q[i + k];
                t_tid[i]  = tid_q[i + k];
                t_mem[i]  = mem_q[i + k];
                t_dead[i] = dead_q[i + k] ||
                            (sq_v && tid_q[i + k] == sq_tid && seq_q[i + k] > sq_seq);
            end else begin
                t_seq[i]  = '0;
                t_tid[i]  = '0;
                t_mem[i]  = 1'b0;
                t_dead[i] = 1'b0;
            end
        end
        pos = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < live && t_seq[i] < push_seq) pos++;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (push_v && i > pos) begin
                n_seq[i]  = t_seq[i - 1];
                n_tid[i]  = t_tid[i - 1];
                n_mem[i]  = t_mem[i - 1];
                n_dead[i] = t_dead[i - 1];
            end else if (push_v && i == pos) begin
                n_seq[i]  = push_seq;
                n_tid[i]  = push_tid;
                n_mem[i]  = push_mem;
                n_dead[i] = push_dead;
            end else begin
                n_seq[i]  = t_seq[i];
                n_tid[i]  = t_tid[i];
                n_mem[i]  = t_mem[i];
                n_dead[i] = t_dead[i];
            end
        end
        n_cnt = CNT_W'(live + (push_v ? 1 : 0));
    end

    // Queue storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mem_q  <= '0;
            dead_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                seq_q[i] <= '0;
                tid_q[i] <= '0;
            end
        end else begin
            cnt_q  <= n_cnt;
            mem_q  <= n_mem;
            dead_q <= n_dead;
            for (int i = 0; i < DEPTH; i++) begin
                seq_q[i] <= n_seq[i];
                tid_q[i] <= n_tid[i];
            end
        end
    end
endmodule

// File: rtl/ois_age_arbiter.sv
// Grants classes in ascending order of their front sequence number.
// A class is reached by the walk when fewer than ISSUE_W older classes were
// granted; reached classes without a unit are reported busy instead.
// Assumes the fronts of different classes never carry equal sequence numbers.
module ois_age_arbiter #(
    parameter int NUM_CLASSES = 4,
    parameter int ISSUE_W     = 2,
    parameter int SEQ_W       = 8
) (
    input  logic                         go,
    input  logic [NUM_CLASSES-1:0]       head_v,
    input  logic [NUM_CLASSES*SEQ_W-1:0] head_seq,
    input  logic [NUM_CLASSES-1:0]       elig,
    output logic [NUM_CLASSES-1:0]       grant,
    output logic [NUM_CLASSES-1:0]       busy
);
    // Rank each class by the eligible older fronts ahead of it.
    always_comb begin
        for (int c = 0; c < NUM_CLASSES; c++) begin
            int older;
            older = 0;
            for (int d = 0; d < NUM_CLASSES; d++) begin
                if (d != c && head_v[d] && elig[d] &&
                    head_seq[d*SEQ_W +: SEQ_W] < head_seq[c*SEQ_W +: SEQ_W])
                    older++;
            end
            grant[c] = go && head_v[c] && elig[c] && (older < ISSUE_W);
            busy[c]  = go && head_v[c] && !elig[c] && (older < ISSUE_W);
        end
    end
endmodule

// File: rtl/ois_fu_timer.sv
// Tells the unit pool when one class's unit may be reused.
// Fast variant: one cycle after issue. Held variant (unpipelined, LAT>1):
// exactly LAT cycles after issue. Assumes the pool withholds the unit meanwhile.
module ois_fu_timer #(
    parameter int LAT       = 1,
    parameter bit PIPELINED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic unit_free
);
    generate
        if (ois_pkg::early_free(LAT, PIPELINED)) begin : g_fast
            logic rel_q;
            // Hand the unit back on the following cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) rel_q <= 1'b0;
                else        rel_q <= grant;
            end
            assign unit_free = rel_q;
        end else begin : g_hold
            localparam int CW = $clog2(LAT + 1);
            logic [CW-1:0] left_q;
            // Count down the occupancy of the unpipelined unit.
            always_ff @(posedge clk) begin
                if (!rst_n)             left_q <= '0;
                else if (grant)         left_q <= CW'(LAT);
                else if (left_q != '0)  left_q <= left_q - 1'b1;
            end
            assign unit_free = (left_q == CW'(1));
        end
    endgenerate
endmodule

// File: rtl/oldest_issue_select.sv
// Oldest-first issue selector over NUM_CLASSES operation classes.
// Class 0 needs no functional unit; fu_avail bit c-1 belongs to class c.
// Assumes unique sequence numbers, no push into a full class queue, and
// thread ids below NUM_THREADS.
module oldest_issue_select #(
    parameter int                         NUM_CLASSES = 4,
    parameter int                         ISSUE_W     = 2,
    parameter int                         DEPTH       = 8,
    parameter int                         SEQ_W       = 8,
    parameter int                         NUM_THREADS = 2,
    parameter int                         BUSY_W      = 8,
    parameter logic [NUM_CLASSES*4-1:0]   CLASS_LAT   = 16'h4311,
    parameter logic [NUM_CLASSES-1:0]     CLASS_PIPE  = 4'b0100,
    localparam int                        CLS_W       = $clog2(NUM_CLASSES),
    localparam int                        TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      push_valid,
    input  logic [CLS_W-1:0]                          push_class,
    input  logic [SEQ_W-1:0]                          push_seq,
    input  logic [TID_W-1:0]                          push_tid,
    input  logic                                      push_mem,
    input  logic                                      squash_valid,
    input  logic [TID_W-1:0]                          squash_tid,
    input  logic [SEQ_W-1:0]                          squash_seq,
    input  logic [NUM_CLASSES-2:0]                    fu_avail,
    input  logic                                      exec_ready,
    output logic [NUM_CLASSES-1:0]                    issue_grant,
    output logic [NUM_CLASSES*SEQ_W-1:0]              issue_seq,
    output logic [NUM_CLASSES*TID_W-1:0]              issue_tid,
    output logic [NUM_CLASSES-1:0]                    issue_mem,
    output logic [NUM_CLASSES-1:0]                    fu_release,
    output logic [NUM_CLASSES-1:0]                    entry_release,
    output logic [NUM_CLASSES*NUM_THREADS*BUSY_W-1:0] busy_count
);
    import ois_pkg::*;

    localparam int NCNT = NUM_CLASSES * NUM_THREADS;

    logic [NUM_CLASSES-1:0]       head_v, head_mem, elig, grant, busy;
    logic [NUM_CLASSES*SEQ_W-1:0] head_seq;
    logic [TID_W-1:0]             head_tid [NUM_CLASSES];
    logic [BUSY_W-1:0]            busy_q   [NCNT];

    generate
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
            logic [SEQ_W-1:0] hs;
            ois_class_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_q (
                .clk      (clk),
                .rst_n    (rst_n),
                .push_v   (push_valid && push_class == CLS_W'(c)),
                .push_seq (push_seq),
                .push_tid (push_tid),
                .push_mem (push_mem),
                .sq_v     (squash_valid),
                .sq_tid   (squash_tid),
                .sq_seq   (squash_seq),
                .drop     (exec_ready),
                .pop      (grant[c]),
                .head_v   (head_v[c]),
                .head_seq (hs),
                .head_tid (head_tid[c]),
                .head_mem (head_mem[c])
            );
            assign head_seq[c*SEQ_W +: SEQ_W]  = hs;
            assign issue_tid[c*TID_W +: TID_W] = head_tid[c];

            if (c == 0) begin : g_nofu
                assign elig[c]       = 1'b1;
                assign fu_release[c] = 1'b0;
            end else begin : g_fu
                localparam int C_LAT = int'(CLASS_LAT[c*LAT_W +: LAT_W]);
                assign elig[c] = fu_avail[c-1];
                ois_fu_timer #(.LAT(C_LAT), .PIPELINED(CLASS_PIPE[c])) u_tmr (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .grant     (grant[c]),
                    .unit_free (fu_release[c])
                );
            end
        end

        for (genvar k = 0; k < NCNT; k++) begin : g_bout
            assign busy_count[k*BUSY_W +: BUSY_W] = busy_q[k];
        end
    endgenerate

    ois_age_arbiter #(.NUM_CLASSES(NUM_CLASSES), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W)) u_arb (
        .go       (exec_ready),
        .head_v   (head_v),
        .head_seq (head_seq),
        .elig     (elig),
        .grant    (grant),
        .busy     (busy)
    );

    assign issue_grant = grant;
    assign issue_seq   = head_seq;
    assign issue_mem   = head_mem;

    // Free the queue slot of non-memory instructions on the cycle after issue.
    always_ff @(posedge clk) begin
        if (!rst_n) entry_release <= '0;
        else        entry_release <= grant & ~head_mem;
    end

    // Count unit-busy misses per class and front-entry thread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCNT; k++) busy_q[k] <= '0;
        end else begin
            for (int c = 0; c < NUM_CLASSES; c++) begin
                if (busy[c] && int'(head_tid[c]) < NUM_THREADS)
                    busy_q[c*NUM_THREADS + int'(head_tid[c])] <=
                        busy_q[c*NUM_THREADS + int'(head_tid[c])] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/oldest_issue_select_chk.sv
// Port-level checks for the oldest-first issue selector, bound to every instance.
module oldest_issue_select_chk #(
    parameter int                       NUM_CLASSES = 4,
    parameter int                       ISSUE_W     = 2,
    parameter int                       NUM_THREADS = 2,
    parameter int                       BUSY_W      = 8,
    parameter logic [NUM_CLASSES*4-1:0] CLASS_LAT   = 16'h4311,
    parameter logic [NUM_CLASSES-1:0]   CLASS_PIPE  = 4'b0100
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      exec_ready,
    input logic [NUM_CLASSES-2:0]                    fu_avail,
    input logic [NUM_CLASSES-1:0]                    issue_grant,
    input logic [NUM_CLASSES-1:0]                    issue_mem,
    input logic [NUM_CLASSES-1:0]                    fu_release,
    input logic [NUM_CLASSES-1:0]                    entry_release,
    input logic [NUM_CLASSES*NUM_THREADS*BUSY_W-1:0] busy_count
);
    AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_grant) <= ISSUE_W); // R3

    AST_STALL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_ready |-> issue_grant == '0); // R4

    AST_STALL_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_ready |=> $stable(busy_count)); // R4

    AST_UNIT_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant[NUM_CLASSES-1:1] & ~fu_avail) == '0); // R6

    AST_ENTRY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> entry_release == $past(issue_grant & ~issue_mem)); // R9

    AST_NOFU_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant[0] |=> !fu_release[0]); // R7

    generate
        for (genvar c = 1; c < NUM_CLASSES; c++) begin : g_rel
            if (ois_pkg::early_free(int'(CLASS_LAT[c*4 +: 4]), CLASS_PIPE[c])) begin : g_f
                AST_FAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                    issue_grant[c] |=> fu_release[c]); // R8
            end else begin : g_h
                AST_HELD_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
                    issue_grant[c] |=> !fu_release[c]); // R8
            end
        end
    endgenerate
endmodule

bind oldest_issue_select oldest_issue_select_chk #(
    .NUM_CLASSES (NUM_CLASSES),
    .ISSUE_W     (ISSUE_W),
    .NUM_THREADS (NUM_THREADS),
    .BUSY_W      (BUSY_W),
    .CLASS_LAT   (CLASS_LAT),
    .CLASS_PIPE  (CLASS_PIPE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exec_ready    (exec_ready),
    .fu_avail      (fu_avail),
    .issue_grant   (issue_grant),
    .issue_mem     (issue_mem),
    .fu_release    (fu_release),
    .entry_release (entry_release),
    .busy_count    (busy_count)
);

// File: tb/oldest_issue_select_test.sv
module oldest_issue_select_test;
    localparam int NC = 4, W = 2, DEPTH = 8, SW = 8, TW = 1, NT = 2, BW = 8;
    localparam int LAT_T [NC]  = '{1, 1, 3, 4};
    localparam bit PIPE_T [NC] = '{0, 0, 1, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_valid = 1'b0;
    logic [1:0]        push_class = '0;
    logic [SW-1:0]     push_seq = '0;
    logic [TW-1:0]     push_tid = '0;
    logic              push_mem = 1'b0;
    logic              squash_valid = 1'b0;
    logic [TW-1:0]     squash_tid = '0;
    logic [SW-1:0]     squash_seq = '0;
    logic [NC-2:0]     fu_avail = '1;
    logic              exec_ready = 1'b0;
    logic [NC-1:0]     issue_grant;
    logic [NC*SW-1:0]  issue_seq;
    logic [NC*TW-1:0]  issue_tid;
    logic [NC-1:0]     issue_mem;
    logic [NC-1:0]     fu_release;
    logic [NC-1:0]     entry_release;
    logic [NC*NT*BW-1:0] busy_count;

    oldest_issue_select uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_class(push_class),
        .push_seq(push_seq), .push_tid(push_tid), .push_mem(push_mem),
        .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
        .fu_avail(fu_avail), .exec_ready(exec_ready), .issue_grant(issue_grant),
        .issue_seq(issue_seq), .issue_tid(issue_tid), .issue_mem(issue_mem),
        .fu_release(fu_release), .entry_release(entry_release), .busy_count(busy_count)
    );

    always #5 clk = ~clk;

    typedef struct { int seq; int tid; bit mem; bit sq; } ent_t;
    ent_t mq [NC][$];
    int   busy_m [NC][NT];
    bit   fast_prev [NC];
    bit   erel_prev [NC];
    int   due [NC];
    int   cyc_n = 0;
    int   checks = 0;
    int   fails = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc_n);
        end
    endtask

    // One clock: compare every output against the model, then advance the model.
    task automatic step();
        bit g [NC];
        bit bz [NC];
        bit hv [NC];
        bit vis [NC];
        int hidx [NC];
        int htid [NC];
        int total;
        #2;
        for (int c = 0; c < NC; c++) begin
            hidx[c] = -1;
            for (int i = 0; i < mq[c].size(); i++)
                if (!mq[c][i].sq) begin hidx[c] = i; break; end
            hv[c] = (hidx[c] >= 0);
            htid[c] = hv[c] ? mq[c][hidx[c]].tid : 0;
            g[c] = 0; bz[c] = 0; vis[c] = 0;
        end
        total = 0;
        if (exec_ready) begin
            for (int n = 0; n < NC; n++) begin
                int best;
                best = -1;
                for (int c = 0; c < NC; c++)
                    if (hv[c] && !vis[c] &&
                        (best < 0 || mq[c][hidx[c]].seq < mq[best][hidx[best]].seq))
                        best = c;
                if (best < 0 || total >= W) break;
                vis[best] = 1;
                if (best == 0 || fu_avail[best-1]) begin g[best] = 1; total++; end
                else bz[best] = 1;
            end
        end
        for (int c = 0; c < NC; c++) begin
            chk(issue_grant[c] == g[c], "R2", $sformatf("grant class %0d", c), int'(issue_grant[c]), int'(g[c]));
            if (g[c]) begin
                chk(int'(issue_seq[c*SW +: SW]) == mq[c][hidx[c]].seq, "R1",
                    $sformatf("front seq class %0d", c), int'(issue_seq[c*SW +: SW]), mq[c][hidx[c]].seq);
                chk(int'(issue_tid[c*TW +: TW]) == mq[c][hidx[c]].tid, "R2",
                    $sformatf("front tid class %0d", c), int'(issue_tid[c*TW +: TW]), mq[c][hidx[c]].tid);
                chk(issue_mem[c] == mq[c][hidx[c]].mem, "R2",
                    $sformatf("front mem class %0d", c), int'(issue_mem[c]), int'(mq[c][hidx[c]].mem));
            end
            chk(fu_release[c] == (fast_prev[c] || due[c] == cyc_n), "R8",
                $sformatf("fu_release class %0d", c), int'(fu_release[c]), int'(fast_prev[c] || due[c] == cyc_n));
            chk(entry_release[c] == erel_prev[c], "R9",
                $sformatf("entry_release class %0d", c), int'(entry_release[c]), int'(erel_prev[c]));
            for (int t = 0; t < NT; t++)
                chk(int'(busy_count[((c*NT)+t)*BW +: BW]) == busy_m[c][t], "R6",
                    $sformatf("busy_count class %0d tid %0d", c, t),
                    int'(busy_count[((c*NT)+t)*BW +: BW]), busy_m[c][t]);
        end
        @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            bit gmem;
            gmem = g[c] ? mq[c][hidx[c]].mem : 1'b0;
            if (exec_ready) begin
                if (hv[c]) begin
                    for (int i = 0; i < hidx[c]; i++) void'(mq[c].pop_front());
                    if (g[c]) void'(mq[c].pop_front());
                end else mq[c].delete();
            end
            if (bz[c]) busy_m[c][htid[c]] = (busy_m[c][htid[c]] + 1) % 256;
            fast_prev[c] = g[c] && c != 0 && (LAT_T[c] <= 1 || PIPE_T[c]);
            if (g[c] && c != 0 && !(LAT_T[c] <= 1 || PIPE_T[c])) due[c] = cyc_n + LAT_T[c];
            erel_prev[c] = g[c] && !gmem;
            if (squash_valid)
                for (int i = 0; i < mq[c].size(); i++)
                    if (mq[c][i].tid == int'(squash_tid) && mq[c][i].seq > int'(squash_seq))
                        mq[c][i].sq = 1;
        end
        if (push_valid) begin
            ent_t e;
            int pos;
            e.seq = int'(push_seq); e.tid = int'(push_tid); e.mem = push_mem;
            e.sq  = squash_valid && push_tid == squash_tid && push_seq > squash_seq;
            pos = 0;
            for (int i = 0; i < mq[push_class].size(); i++)
                if (mq[push_class][i].seq < e.seq) pos++;
            mq[push_class].insert(pos, e);
        end
        cyc_n++;
        #1;
    endtask

    task automatic push(int c, int s, int t, bit m);
        push_valid = 1; push_class = 2'(c); push_seq = SW'(s); push_tid = TW'(t); push_mem = m;
        step();
        push_valid = 0;
    endtask

    task automatic squash(int t, int s);
        squash_valid = 1; squash_tid = TW'(t); squash_seq = SW'(s);
        step();
        squash_valid = 0;
    endtask

    function automatic bit seq_used(int s);
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < mq[c].size(); i++)
                if (mq[c][i].seq == s) return 1;
        return 0;
    endfunction

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired (cycle %0d)", cyc_n);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin due[c] = -1; fast_prev[c] = 0; erel_prev[c] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk(issue_grant == '0, "R11", "grant after reset", int'(issue_grant), 0);
        chk(fu_release == '0 && entry_release == '0, "R11", "releases after reset",
            int'({fu_release, entry_release}), 0);
        chk(busy_count == '0, "R11", "busy counters after reset", int'(busy_count != '0), 0);
        rst_n = 1;
        step();

        // R1: an older push overtakes the current front
        push(1, 50, 0, 0);
        push(1, 20, 0, 0);
        exec_ready = 1;
        #1 chk(issue_grant[1] && issue_seq[1*SW +: SW] == 8'd20, "R1", "older push at front",
               int'(issue_seq[1*SW +: SW]), 20);
        repeat (3) step();

        // R4, R3, R2: width limit and age order across classes
        exec_ready = 0;
        push(0, 90, 0, 0);
        push(1, 70, 1, 1);
        push(2, 80, 0, 0);
        push(3, 60, 1, 0);
        #1 chk(issue_grant == '0, "R4", "no grant while stalled", int'(issue_grant), 0);
        step();
        exec_ready = 1;
        #1 chk(issue_grant == 4'b1010, "R3", "two oldest classes granted", int'(issue_grant), 10);
        step();
        #1 chk(issue_grant == 4'b0101, "R2", "remaining classes next", int'(issue_grant), 5);
        repeat (5) step();

        // R7: class 0 needs no unit
        exec_ready = 0;
        push(0, 10, 0, 0);
        fu_avail = '0;
        exec_ready = 1;
        #1 chk(issue_grant == 4'b0001, "R7", "class 0 without unit", int'(issue_grant), 1);
        step();
        fu_avail = '1;
        repeat (4) step();

        // R6: busy unit skipped, younger class issues, counter rises
        exec_ready = 0;
        push(3, 30, 1, 0);
        push(2, 40, 0, 0);
        fu_avail = 3'b011;
        exec_ready = 1;
        #1 chk(issue_grant == 4'b0100, "R6", "busy class skipped", int'(issue_grant), 4);
        step();
        #1 chk(int'(busy_count[((3*NT)+1)*BW +: BW]) == 1, "R6", "busy counter class 3 tid 1",
               int'(busy_count[((3*NT)+1)*BW +: BW]), 1);
        fu_avail = '1;
        repeat (6) step();

        // R10: squash marks only younger entries of one thread
        exec_ready = 0;
        push(1, 100, 0, 0);
        push(1, 200, 0, 0);
        push(1, 150, 1, 0);
        push(2, 120, 0, 0);
        squash(0, 110);
        exec_ready = 1;
        #1 chk(issue_grant == 4'b0010 && issue_seq[1*SW +: SW] == 8'd100, "R10",
               "squash spares older and other thread", int'(issue_grant), 2);
        step();
        #1 chk(issue_grant == 4'b0010 && issue_seq[1*SW +: SW] == 8'd150, "R10",
               "other thread survives", int'(issue_seq[1*SW +: SW]), 150);
        repeat (4) step();

        // R5: squashed front dropped without using width
        exec_ready = 0;
        push(3, 5, 0, 0);
        push(3, 7, 1, 1);
        push(1, 9, 1, 0);
        squash(0, 3);
        exec_ready = 1;
        #1 chk(issue_grant == 4'b1010 && issue_seq[3*SW +: SW] == 8'd7, "R5",
               "live entry behind squashed front", int'(issue_seq[3*SW +: SW]), 7);
        repeat (6) step();

        // Random traffic checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            exec_ready = ($urandom_range(99) < 85);
            fu_avail   = 3'($urandom);
            push_valid = 0;
            if ($urandom_range(99) < 70) begin
                int c;
                int s;
                c = $urandom_range(NC - 1);
                if (mq[c].size() < DEPTH) begin
                    do s = $urandom_range(255); while (seq_used(s));
                    push_valid = 1; push_class = 2'(c); push_seq = SW'(s);
                    push_tid = TW'($urandom_range(1)); push_mem = 1'($urandom_range(1));
                end
            end
            squash_valid = ($urandom_range(99) < 5);
            squash_tid   = TW'($urandom_range(1));
            squash_seq   = SW'($urandom_range(255));
            step();
        end
        push_valid = 0; squash_valid = 0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule